// File: doc/BRIEF.md
# Multi-Channel Interrupt Source Aggregator

This block gathers service requests from eight serial channels, a shared timer and a sleep wake-up event, and presents them to a host as four read-only byte registers. The first register is a flat vector with one pending flag per channel. The other three registers together form a 24-bit field holding a 3-bit source code for every channel. A single active-high interrupt line is raised whenever any flag is set.

Each channel supplies the code of its highest-priority pending source, already filtered by that channel's own enables. The block latches it and keeps it until the channel's clear strobe arrives. The strobe is raised by surrounding logic when one of that channel's status registers is read. While a code is held, a more urgent code replaces it, and a less urgent one does not. The shared timer and the wake-up event report only through channel 0, using code 7. Each has its own enable. A wake-up counts only if every channel was asleep in the cycle before it.

Each channel runs a two-state machine, `CH_IDLE` and `CH_HELD`. Its transitions are LATCH (IDLE to HELD on a valid code), PROMOTE (HELD to HELD with a more urgent code), RELATCH (HELD to HELD when a clear and a valid code meet) and RELEASE (HELD to IDLE on a clear with no valid code). The shared event machine has `SH_QUIET` and `SH_RAISED`. Its transitions are RAISE (QUIET to RAISED on an enabled timer expiry or a qualified wake) and DROP (RAISED to QUIET on a channel 0 clear with no new event).

Top module: `chan_irq_collector`

## Requirements
- R1: After reset all four registers read zero and `irq_o` is low.
- R2: A valid source code (1 line status, 2 receive data or timeout, 3 transmitter empty, 4 modem status) on channel N sets bit N of `reg_pend_o` one clock later.
- R3: The code held for channel k appears at bits [3k+2:3k] of the 24-bit field {`reg_src2_o`, `reg_src1_o`, `reg_src0_o`}. A channel that is not pending shows 0.
- R4: While a channel is held, an incoming code with a smaller nonzero value replaces the held code. A larger value leaves it unchanged.
- R5: Channel inputs 5, 6 and 7 are treated as no source. Code 7 never appears in the fields of channels 1 to 7.
- R6: A clear strobe on a held channel empties its flag and code one clock later. If a valid code is present in the same cycle, the channel instead holds that new code. A clear on an idle channel has no effect.
- R7: A timer expiry with the timer enable high makes channel 0 pending with code 7. With the enable low, the expiry is ignored.
- R8: On channel 0, a held channel code is shown in place of code 7.
- R9: A wake event with the wake enable high makes channel 0 pending with code 7, but only if all eight sleep inputs were high in the previous cycle.
- R10: The channel 0 clear also drops the timer and wake condition. An enabled timer expiry in the same cycle as the clear keeps it raised.
- R11: `irq_o` is high exactly when any bit of `reg_pend_o` is set.
- R12: A clear strobe on one channel leaves every other channel's flag and code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_src_i | input | 24 | Per-channel highest-priority source code, channel k at [3k+2:3k] |
| chan_clr_i | input | 8 | Per-channel clear strobe from a status register read |
| chan_sleep_i | input | 8 | Per-channel sleep mode indication |
| tmr_expire_i | input | 1 | Shared timer expiry pulse |
| tmr_en_i | input | 1 | Timer interrupt enable |
| wake_i | input | 1 | Wake-up event pulse |
| wake_en_i | input | 1 | Wake-up interrupt enable |
| reg_pend_o | output | 8 | Pending flag per channel |
| reg_src0_o | output | 8 | Source field bits [7:0] |
| reg_src1_o | output | 8 | Source field bits [15:8] |
| reg_src2_o | output | 8 | Source field bits [23:16] |
| irq_o | output | 1 | Global interrupt, active high |

## Verification
Two functions can land on the same clock edge. A clear strobe can meet a fresh source code on the same channel, and a channel 0 clear can meet an enabled timer expiry. The bench drives both inputs in one cycle and expects the new request to survive. For a channel, the held code must become the incoming one. For the timer, channel 0 must still show code 7. The clears are then repeated with no source present, and the registers must return to zero.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int NCH     = 8;
    localparam int CODE_W  = 3;
    localparam int FIELD_W = NCH * CODE_W;
    localparam int REG_W   = 8;

    typedef logic [CODE_W-1:0] src_code_t;

    localparam src_code_t SRC_NONE    = 3'd0;
    localparam src_code_t SRC_LINE    = 3'd1;
    localparam src_code_t SRC_RXDATA  = 3'd2;
    localparam src_code_t SRC_TXEMPTY = 3'd3;
    localparam src_code_t SRC_MODEM   = 3'd4;
    localparam src_code_t SRC_SHARED  = 3'd7;

    typedef enum logic {CH_IDLE, CH_HELD}    ch_state_t;
    typedef enum logic {SH_QUIET, SH_RAISED} sh_state_t;

    function automatic logic code_valid(src_code_t c);
        return (c >= SRC_LINE) && (c <= SRC_MODEM);
    endfunction
endpackage

// File: rtl/chan_src_latch.sv
module chan_src_latch
    import irqagg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  src_code_t src_i,
    input  logic      clr_i,
    output logic      held_o,
    output src_code_t code_o
);
    ch_state_t state_q, state_d;
    src_code_t code_q, code_d;
    logic      in_ok;

    assign in_ok = code_valid(src_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            code_q  <= SRC_NONE;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            CH_IDLE: begin
                if (in_ok) begin              // LATCH
                    state_d = CH_HELD;
                    code_d  = src_i;
                end
            end
            CH_HELD: begin
                if (clr_i) begin
                    if (in_ok) begin          // RELATCH
                        code_d = src_i;
                    end else begin            // RELEASE
                        state_d = CH_IDLE;
                        code_d  = SRC_NONE;
                    end
                end else if (in_ok && (src_i < code_q)) begin
                    code_d = src_i;           // PROMOTE
                end
            end
        endcase
    end

    always_comb begin
        held_o = (state_q == CH_HELD);
        code_o = code_q;
    end

    assert_held_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HELD) |-> code_valid(code_q));

    assert_idle_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE) |-> (code_q == SRC_NONE));

    assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && code_valid(src_i)) |=> (held_o && code_q == $past(src_i)));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HELD && clr_i && !code_valid(src_i)) |=> (!held_o && code_q == SRC_NONE));

    assert_no_demote_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HELD && !clr_i) |=> (held_o && code_q <= $past(code_q)));
endmodule

// File: rtl/shared_evt_latch.sv
module shared_evt_latch
    import irqagg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sleep_i,
    input  logic           tmr_expire_i,
    input  logic           tmr_en_i,
    input  logic           wake_i,
    input  logic           wake_en_i,
    input  logic           clr_i,
    output logic           raised_o
);
    sh_state_t sh_q, sh_d;
    logic      armed_q;
    logic      tmr_hit, wake_hit, any_hit;

    assign tmr_hit  = tmr_expire_i & tmr_en_i;
    assign wake_hit = wake_i & wake_en_i & armed_q;
    assign any_hit  = tmr_hit | wake_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= SH_QUIET;
            armed_q <= 1'b0;
        end else begin
            sh_q    <= sh_d;
            armed_q <= &sleep_i;
        end
    end

    always_comb begin
        sh_d = sh_q;
        unique case (sh_q)
            SH_QUIET:  if (any_hit)            sh_d = SH_RAISED;  // RAISE
            SH_RAISED: if (clr_i && !any_hit)  sh_d = SH_QUIET;   // DROP
        endcase
    end

    always_comb begin
        raised_o = (sh_q == SH_RAISED);
    end

    assert_timer_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q == SH_QUIET && !(tmr_expire_i && tmr_en_i) && !(wake_i && wake_en_i))
        |=> (sh_q == SH_QUIET));

    assert_wake_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q == SH_QUIET && !(tmr_expire_i && tmr_en_i) && !armed_q) |=> (sh_q == SH_QUIET));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_expire_i && tmr_en_i) |=> raised_o);
endmodule

// File: rtl/src_field_pack.sv
module src_field_pack
    import irqagg_pkg::*;
(
    input  logic [NCH-1:0]     held_i,
    input  logic [FIELD_W-1:0] codes_i,
    input  logic               shared_i,
    output logic [NCH-1:0]     pend_o,
    output logic [FIELD_W-1:0] field_o
);
    always_comb begin
        pend_o  = held_i;
        field_o = codes_i;
        pend_o[0] = held_i[0] | shared_i;
        if (!held_i[0] && shared_i) begin
            field_o[CODE_W-1:0] = SRC_SHARED;
        end
    end
endmodule

// File: rtl/chan_irq_collector.sv
module chan_irq_collector
    import irqagg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FIELD_W-1:0]   chan_src_i,
    input  logic [NCH-1:0]       chan_clr_i,
    input  logic [NCH-1:0]       chan_sleep_i,
    input  logic                 tmr_expire_i,
    input  logic                 tmr_en_i,
    input  logic                 wake_i,
    input  logic                 wake_en_i,
    output logic [REG_W-1:0]     reg_pend_o,
    output logic [REG_W-1:0]     reg_src0_o,
    output logic [REG_W-1:0]     reg_src1_o,
    output logic [REG_W-1:0]     reg_src2_o,
    output logic                 irq_o
);
    logic [NCH-1:0]     held;
    logic [FIELD_W-1:0] lat_codes;
    logic [NCH-1:0]     pend;
    logic [FIELD_W-1:0] field;
    logic               shared_raised;

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        chan_src_latch u_lat (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (chan_src_i[k*CODE_W +: CODE_W]),
            .clr_i  (chan_clr_i[k]),
            .held_o (held[k]),
            .code_o (lat_codes[k*CODE_W +: CODE_W])
        );
    end

    shared_evt_latch u_shared (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_i      (chan_sleep_i),
        .tmr_expire_i (tmr_expire_i),
        .tmr_en_i     (tmr_en_i),
        .wake_i       (wake_i),
        .wake_en_i    (wake_en_i),
        .clr_i        (chan_clr_i[0]),
        .raised_o     (shared_raised)
    );

    src_field_pack u_pack (
        .held_i   (held),
        .codes_i  (lat_codes),
        .shared_i (shared_raised),
        .pend_o   (pend),
        .field_o  (field)
    );

    assign reg_pend_o = pend;
    assign reg_src0_o = field[7:0];
    assign reg_src1_o = field[15:8];
    assign reg_src2_o = field[23:16];
    assign irq_o      = |pend;

    for (genvar k = 1; k < NCH; k++) begin : g_rsv
        assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
            field[k*CODE_W +: CODE_W] != SRC_SHARED);
    end

    assert_ch0_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        held[0] |-> (field[CODE_W-1:0] == lat_codes[CODE_W-1:0]));

    assert_shared_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shared_raised |-> (reg_pend_o[0] && irq_o));
endmodule

// File: tb/chan_irq_collector_tb.sv
`timescale 1ns/1ps
module chan_irq_collector_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] chan_src_i;
    logic [7:0]  chan_clr_i, chan_sleep_i;
    logic        tmr_expire_i, tmr_en_i, wake_i, wake_en_i;
    logic [7:0]  reg_pend_o, reg_src0_o, reg_src1_o, reg_src2_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_code [8];

    always #4 clk = ~clk;

    chan_irq_collector u_dut (
        .clk(clk), .rst_n(rst_n), .chan_src_i(chan_src_i), .chan_clr_i(chan_clr_i),
        .chan_sleep_i(chan_sleep_i), .tmr_expire_i(tmr_expire_i), .tmr_en_i(tmr_en_i),
        .wake_i(wake_i), .wake_en_i(wake_en_i), .reg_pend_o(reg_pend_o),
        .reg_src0_o(reg_src0_o), .reg_src1_o(reg_src1_o), .reg_src2_o(reg_src2_o),
        .irq_o(irq_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_exp();
        for (int k = 0; k < 8; k++) exp_code[k] = 0;
    endtask

    task automatic check_regs(string tag);
        logic [23:0] ef;
        logic [7:0]  ep;
        logic [32:0] act, exp;
        for (int k = 0; k < 8; k++) begin
            ef[k*3 +: 3] = exp_code[k][2:0];
            ep[k]        = (exp_code[k] != 0);
        end
        exp = {|ep, ep, ef};
        act = {irq_o, reg_pend_o, reg_src2_o, reg_src1_o, reg_src0_o};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(8 * 50000);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; chan_src_i = '0; chan_clr_i = '0; chan_sleep_i = '0;
        tmr_expire_i = 0; tmr_en_i = 0; wake_i = 0; wake_en_i = 0;
        clear_exp();
        repeat (3) step();
        check_regs("R1 during reset");
        rst_n = 1'b1;
        step();
        check_regs("R1 after reset");

        // R2 R3 R5 R6 sweep: every channel, every input code
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 8; c++) begin
                chan_src_i[k*3 +: 3] = 3'(c);
                step();
                exp_code[k] = (c >= 1 && c <= 4) ? c : 0;
                check_regs("R2 R3 R5 R11 latch sweep");
                chan_src_i = '0;
                chan_clr_i[k] = 1'b1;
                step();
                chan_clr_i = '0;
                exp_code[k] = 0;
                check_regs("R6 clear sweep");
            end
        end

        // R4 priority replacement on channel 3
        for (int a = 1; a <= 4; a++) begin
            for (int b = 1; b <= 4; b++) begin
                chan_src_i[9 +: 3] = 3'(a);
                step();
                chan_src_i[9 +: 3] = 3'(b);
                step();
                chan_src_i = '0;
                exp_code[3] = (a < b) ? a : b;
                check_regs("R4 priority");
                chan_clr_i[3] = 1'b1;
                step();
                chan_clr_i = '0;
                exp_code[3] = 0;
                check_regs("R6 clear after R4");
            end
        end

        // R6 clear meets a fresh code on channel 6
        chan_src_i[18 +: 3] = 3'd4;
        step();
        chan_src_i[18 +: 3] = 3'd2;
        chan_clr_i[6] = 1'b1;
        step();
        chan_src_i = '0; chan_clr_i = '0;
        exp_code[6] = 2;
        check_regs("R6 relatch on collision");
        chan_clr_i[6] = 1'b1;
        step();
        chan_clr_i = '0;
        exp_code[6] = 0;
        check_regs("R6 release");
        chan_clr_i = 8'hFF;
        step();
        chan_clr_i = '0;
        check_regs("R6 clear on idle ignored");

        // R12 isolation
        for (int k = 0; k < 8; k++) begin
            chan_src_i[k*3 +: 3] = 3'((k % 4) + 1);
            exp_code[k] = (k % 4) + 1;
        end
        step();
        chan_src_i = '0;
        check_regs("R12 all loaded");
        chan_clr_i[5] = 1'b1;
        step();
        chan_clr_i = '0;
        exp_code[5] = 0;
        check_regs("R12 single clear");
        chan_clr_i = 8'hFF;
        step();
        chan_clr_i = '0;
        clear_exp();
        check_regs("R12 all cleared");

        // R7 timer masking
        tmr_expire_i = 1;
        step();
        tmr_expire_i = 0;
        check_regs("R7 masked timer");
        tmr_en_i = 1; tmr_expire_i = 1;
        step();
        tmr_expire_i = 0;
        exp_code[0] = 7;
        check_regs("R7 timer on channel 0");
        // R8 channel code outranks timer
        chan_src_i[2:0] = 3'd3;
        step();
        chan_src_i = '0;
        exp_code[0] = 3;
        check_regs("R8 channel code over timer");
        chan_clr_i[0] = 1'b1;
        step();
        chan_clr_i = '0;
        exp_code[0] = 0;
        check_regs("R10 clear drops both");
        // R10 expiry meets clear
        tmr_expire_i = 1;
        step();
        chan_clr_i[0] = 1'b1;
        step();
        tmr_expire_i = 0; chan_clr_i = '0;
        exp_code[0] = 7;
        check_regs("R10 expiry wins over clear");
        chan_clr_i[0] = 1'b1;
        step();
        chan_clr_i = '0;
        exp_code[0] = 0;
        check_regs("R10 shared cleared");
        tmr_en_i = 0;

        // R9 wake qualified by all channels asleep
        wake_en_i = 1;
        chan_sleep_i = 8'hFF;
        step();
        chan_sleep_i = '0; wake_i = 1;
        step();
        wake_i = 0;
        exp_code[0] = 7;
        check_regs("R9 wake after all asleep");
        chan_clr_i[0] = 1'b1;
        step();
        chan_clr_i = '0;
        exp_code[0] = 0;
        check_regs("R9 wake cleared");
        for (int k = 0; k < 8; k++) begin
            chan_sleep_i = ~(8'h01 << k);
            step();
            chan_sleep_i = '0; wake_i = 1;
            step();
            wake_i = 0;
            check_regs("R9 one channel awake");
        end
        wake_en_i = 0;
        chan_sleep_i = 8'hFF;
        step();
        chan_sleep_i = '0; wake_i = 1;
        step();
        wake_i = 0;
        check_regs("R9 wake disabled");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule